// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns one decoded memory-transfer instruction into a string of byte-wide bus requests. It also reports the effective address and the base-register update that the instruction implies. A single transfer takes a base value and an offset. The offset is either a zero-extended 12-bit immediate or a register value that has already been shifted. Five control bits shape the transfer. `pre_idx` applies the offset before the access (set) or after it (clear). `add_off` adds the offset (set) or subtracts it (clear). `byte_xfer` asks for a one-byte transfer. `wb_req` asks for a base update. `load` selects a read (set) or a write (clear). When `pc_rel` is set, 8 is added to the base before any other arithmetic.

In block mode, a 16-bit register list replaces the offset. The selected registers move lowest index first, one word each, at addresses that rise by 4 per register. `pre_idx` and `add_off` together choose one of four start addresses. Every word access is split into four byte requests on a little-endian byte bus. The word address has its two low bits cleared. The byte at offset k fills bits 8k+7:8k of the word. The register file is outside the block. It supplies store data for the register named on `xfer_reg` and accepts load words on `ld_valid`.

Top module: `lsagu_top`

## Requirements
- R1: For a single transfer with `pre_idx`=1, `eff_addr` equals base plus the offset when `add_off`=1 and base minus the offset when `add_off`=0. The immediate offset is a 12-bit unsigned value, so 0xFFF adds 4095. When `off_is_reg`=1, `reg_off` is used as the offset instead.
- R2: For a single transfer with `pre_idx`=0, `eff_addr` equals the unmodified base.
- R3: For a single transfer, `wb_en` is 1 exactly when `pre_idx`=0 or `wb_req`=1. `wb_val` is base ± offset, and both values stay constant while `busy` is high.
- R4: A word access issues four consecutive byte requests at A, A+1, A+2 and A+3, where A is `eff_addr` with bits 1:0 cleared. On a load, the byte read at offset k lands in bits 8k+7:8k of `ld_word`, which is flagged by a one-cycle `ld_valid`.
- R5: A single byte access issues exactly one request, at the unaligned `eff_addr`. A byte load returns the byte zero-extended in `ld_word`.
- R6: A block transfer moves the registers whose bits are set in `reg_list` in ascending index order. `xfer_reg` names the register being moved, and the word address rises by 4 for each register.
- R7: The block start address is set by {`pre_idx`,`add_off`}. For n listed registers: 10 gives base−4n, 00 gives base−4n+4, 01 gives base, and 11 gives base+4.
- R8: For a block transfer, `wb_en` equals `wb_req`. `wb_val` is base+4n when `add_off`=1 and base−4n when `add_off`=0.
- R9: When `pc_rel`=1, the base used for every address and writeback value is `base_val`+8.
- R10: After reset, `busy`, `done`, `bus_req` and `ld_valid` are 0. A `start` while idle makes `busy` high on the next cycle, with one request per cycle. `done` pulses for one cycle right after the last request. A `start` while busy is ignored. A block with an empty list makes no request and pulses `done` two cycles after `start`.
- R11: On a store, `bus_we` is 1 on every request. The byte at word offset k is `st_data` bits 8k+7:8k, and a byte store drives `st_data` bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new transfer when idle |
| blk_mode | input | 1 | 1 = register-list block transfer |
| pre_idx | input | 1 | 1 = offset applied before the access |
| add_off | input | 1 | 1 = add offset, 0 = subtract |
| byte_xfer | input | 1 | 1 = single byte access (single mode only) |
| wb_req | input | 1 | Writeback requested |
| load | input | 1 | 1 = load, 0 = store |
| pc_rel | input | 1 | Base is the program counter; add 8 |
| off_is_reg | input | 1 | 1 = use reg_off, 0 = use imm_off |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Pre-shifted register offset |
| base_val | input | 32 | Base register value |
| reg_list | input | 16 | Register list for block mode |
| st_data | input | 32 | Store word for the register named by xfer_reg |
| bus_rdata | input | 8 | Read byte for the current request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| bus_req | output | 1 | Byte request valid |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 32 | Byte address of the request |
| bus_wdata | output | 8 | Write byte |
| xfer_reg | output | 4 | Register currently transferred |
| ld_valid | output | 1 | Load word complete |
| ld_word | output | 32 | Assembled load word |
| ld_reg | output | 4 | Register that ld_word belongs to |
| eff_addr | output | 32 | Effective / start address |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | 32 | Base writeback value |

## Verification
Single transfers cover both index timings, both offset signs, both offset sources, the largest immediate and the PC-relative base. These cases separate the address taken for the access from the value written back, and they show when the writeback rule asserts `wb_en`. Block transfers cover all four {`pre_idx`,`add_off`} start modes with lists of different sizes and sparse bit patterns, including one that spans register 0 to register 15. These show the start offset, the ascending order and the ±4n writeback. Loads and stores of both sizes, with byte values that differ per address, confirm lane placement, the four-request split versus the single unaligned request, and zero-extension. Directed cases cover the reset state, a `start` issued while busy, and an empty register list.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LANE_W     = 2;
  localparam int BYTE_W     = 8;

  // block start mode, encoded as {pre_idx, add_off}
  typedef enum logic [1:0] {
    BLK_DEC_AFTER  = 2'b00,
    BLK_INC_AFTER  = 2'b01,
    BLK_DEC_BEFORE = 2'b10,
    BLK_INC_BEFORE = 2'b11
  } blk_mode_e;
endpackage

// File: rtl/lsagu_addr.sv
module lsagu_addr
  import lsagu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LIST_W   = 16,
  parameter int IMM_W    = 12,
  parameter int PC_AHEAD = 8
) (
  input  logic              blk,
  input  logic              pre,
  input  logic              up,
  input  logic              wback,
  input  logic              pc_rel,
  input  logic              off_is_reg,
  input  logic [IMM_W-1:0]  imm,
  input  logic [AW-1:0]     reg_off,
  input  logic [AW-1:0]     base,
  input  logic [LIST_W-1:0] list,
  output logic [AW-1:0]     eff,
  output logic              wb_en,
  output logic [AW-1:0]     wb_val
);
  localparam int CNT_W = $clog2(LIST_W + 1);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    span, base_adj, offs, idx_val;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < LIST_W; i++) cnt = cnt + CNT_W'(list[i]);
  end

  assign span     = AW'(cnt) << 2;
  assign base_adj = base + (pc_rel ? AW'(PC_AHEAD) : '0);
  assign offs     = off_is_reg ? reg_off : AW'(imm);
  assign idx_val  = up ? base_adj + offs : base_adj - offs;

  always_comb begin
    if (blk) begin
      unique case (blk_mode_e'({pre, up}))
        BLK_DEC_BEFORE: eff = base_adj - span;
        BLK_DEC_AFTER:  eff = base_adj - span + STEP;
        BLK_INC_AFTER:  eff = base_adj;
        default:        eff = base_adj + STEP;
      endcase
      wb_en  = wback;
      wb_val = up ? base_adj + span : base_adj - span;
    end else begin
      eff    = pre ? idx_val : base_adj;
      wb_en  = !pre || wback;
      wb_val = idx_val;
    end
  end
endmodule

// File: rtl/lsagu_seq.sv
module lsagu_seq
  import lsagu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LIST_W = 16,
  localparam int RW    = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              blk,
  input  logic              bytes,
  input  logic              load,
  input  logic [AW-1:0]     addr,
  input  logic [LIST_W-1:0] list,
  output logic              busy,
  output logic              done,
  output logic              req,
  output logic              we,
  output logic [AW-1:0]     req_addr,
  output logic [LANE_W-1:0] lane,
  output logic              byte_mode,
  output logic              word_end,
  output logic [RW-1:0]     cur_reg
);
  logic              busy_q, done_q, byte_q, load_q;
  logic [LIST_W-1:0] mask_q, low_bit;
  logic [AW-1:0]     waddr_q;
  logic [LANE_W-1:0] lane_q;

  always_comb begin
    cur_reg = '0;
    for (int i = LIST_W - 1; i >= 0; i--)
      if (mask_q[i]) cur_reg = RW'(i);
  end

  assign low_bit   = mask_q & (~mask_q + LIST_W'(1));
  assign req       = busy_q && (|mask_q);
  assign we        = req && !load_q;
  assign req_addr  = byte_q ? waddr_q : {waddr_q[AW-1:LANE_W], lane_q};
  assign word_end  = req && (byte_q || lane_q == {LANE_W{1'b1}});
  assign lane      = lane_q;
  assign byte_mode = byte_q;
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      byte_q  <= 1'b0;
      load_q  <= 1'b0;
      mask_q  <= '0;
      waddr_q <= '0;
      lane_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          mask_q  <= blk ? list : LIST_W'(1);
          byte_q  <= bytes && !blk;
          load_q  <= load;
          lane_q  <= '0;
          waddr_q <= (bytes && !blk) ? addr : {addr[AW-1:LANE_W], {LANE_W{1'b0}}};
        end
      end else if (!(|mask_q)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (word_end) begin
        lane_q  <= '0;
        mask_q  <= mask_q & ~low_bit;
        waddr_q <= waddr_q + AW'(WORD_BYTES);
        if ((mask_q & ~low_bit) == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        lane_q <= lane_q + LANE_W'(1);
      end
    end
  end
endmodule

// File: rtl/lsagu_ldpack.sv
module lsagu_ldpack
  import lsagu_pkg::*;
#(
  parameter int DW     = 32,
  parameter int RW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              word_end,
  input  logic              byte_mode,
  input  logic [LANE_W-1:0] lane,
  input  logic [BYTE_W-1:0] rdata,
  input  logic [RW-1:0]     reg_idx,
  output logic              ld_valid,
  output logic [DW-1:0]     ld_word,
  output logic [RW-1:0]     ld_reg
);
  logic [DW-1:0] acc_q;
  logic          vld_q;
  logic [RW-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      vld_q <= 1'b0;
      reg_q <= '0;
    end else begin
      vld_q <= capture && word_end;
      if (capture) begin
        if (byte_mode) acc_q <= DW'(rdata);
        else           acc_q[lane*BYTE_W +: BYTE_W] <= rdata;
        if (word_end) reg_q <= reg_idx;
      end
    end
  end

  assign ld_valid = vld_q;
  assign ld_word  = acc_q;
  assign ld_reg   = reg_q;
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
  import lsagu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LIST_W   = 16,
  parameter int IMM_W    = 12,
  parameter int PC_AHEAD = 8,
  localparam int RW      = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              blk_mode,
  input  logic              pre_idx,
  input  logic              add_off,
  input  logic              byte_xfer,
  input  logic              wb_req,
  input  logic              load,
  input  logic              pc_rel,
  input  logic              off_is_reg,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [AW-1:0]     reg_off,
  input  logic [AW-1:0]     base_val,
  input  logic [LIST_W-1:0] reg_list,
  input  logic [DW-1:0]     st_data,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic [RW-1:0]     xfer_reg,
  output logic              ld_valid,
  output logic [DW-1:0]     ld_word,
  output logic [RW-1:0]     ld_reg,
  output logic [AW-1:0]     eff_addr,
  output logic              wb_en,
  output logic [AW-1:0]     wb_val
);
  logic [AW-1:0]     eff_c, wbv_c, eff_q, wbv_q;
  logic              wbe_c, wbe_q, accept;
  logic [LANE_W-1:0] lane;
  logic              byte_mode, word_end;

  lsagu_addr #(.AW(AW), .LIST_W(LIST_W), .IMM_W(IMM_W), .PC_AHEAD(PC_AHEAD)) u_addr (
    .blk(blk_mode), .pre(pre_idx), .up(add_off), .wback(wb_req), .pc_rel(pc_rel),
    .off_is_reg(off_is_reg), .imm(imm_off), .reg_off(reg_off), .base(base_val),
    .list(reg_list), .eff(eff_c), .wb_en(wbe_c), .wb_val(wbv_c)
  );

  lsagu_seq #(.AW(AW), .LIST_W(LIST_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .blk(blk_mode), .bytes(byte_xfer),
    .load(load), .addr(eff_c), .list(reg_list), .busy(busy), .done(done),
    .req(bus_req), .we(bus_we), .req_addr(bus_addr), .lane(lane),
    .byte_mode(byte_mode), .word_end(word_end), .cur_reg(xfer_reg)
  );

  lsagu_ldpack #(.DW(DW), .RW(RW)) u_ld (
    .clk(clk), .rst(rst), .capture(bus_req && !bus_we), .word_end(word_end),
    .byte_mode(byte_mode), .lane(lane), .rdata(bus_rdata), .reg_idx(xfer_reg),
    .ld_valid(ld_valid), .ld_word(ld_word), .ld_reg(ld_reg)
  );

  assign accept    = start && !busy;
  assign bus_wdata = byte_mode ? st_data[BYTE_W-1:0] : st_data[lane*BYTE_W +: BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q <= '0;
      wbv_q <= '0;
      wbe_q <= 1'b0;
    end else if (accept) begin
      eff_q <= eff_c;
      wbv_q <= wbv_c;
      wbe_q <= wbe_c;
    end
  end

  assign eff_addr = eff_q;
  assign wb_val   = wbv_q;
  assign wb_en    = wbe_q;
endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          wb_en,
  input logic [AW-1:0] wb_val,
  input logic          ld_valid
);
  // R10: no bus activity while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);
  // R10: done only right after a busy cycle
  a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: back-to-back requests walk the byte lanes upward
  a_r4_lane_step: assert property (@(posedge clk) disable iff (rst)
    bus_req && $past(bus_req) |-> bus_addr[1:0] == $past(bus_addr[1:0]) + 2'd1);
  // R11: direction does not change within a transfer
  a_r11_dir_hold: assert property (@(posedge clk) disable iff (rst)
    bus_req && $past(bus_req) |-> bus_we == $past(bus_we));
  // R3: writeback outputs are stable while busy
  a_r3_wb_hold: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(wb_val) && $stable(wb_en));
  // R4: a load word appears only after a read request
  a_r4_ld_after_read: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(bus_req) && !$past(bus_we));
endmodule

bind lsagu_top lsagu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .wb_en(wb_en), .wb_val(wb_val),
  .ld_valid(ld_valid)
);

// File: tb/sim_lsagu_top.sv
`timescale 1ns/1ps
module sim_lsagu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, blk_mode = 1'b0, pre_idx = 1'b0, add_off = 1'b0;
  logic        byte_xfer = 1'b0, wb_req = 1'b0, load = 1'b0, pc_rel = 1'b0, off_is_reg = 1'b0;
  logic [11:0] imm_off = '0;
  logic [31:0] reg_off = '0, base_val = '0, st_data;
  logic [15:0] reg_list = '0;
  logic [7:0]  bus_rdata, bus_wdata;
  logic        busy, done, bus_req, bus_we, ld_valid, wb_en;
  logic [31:0] bus_addr, ld_word, eff_addr, wb_val;
  logic [3:0]  xfer_reg, ld_reg;
  logic [7:0]  mem [256];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lsagu_top u0 (.*);

  // store word: byte k = {k+1, register}
  assign st_data   = {4'h4, xfer_reg, 4'h3, xfer_reg, 4'h2, xfer_reg, 4'h1, xfer_reg};
  assign bus_rdata = mem[bus_addr[7:0]];
  always @(posedge clk) if (bus_req && bus_we) mem[bus_addr[7:0]] <= bus_wdata;

  typedef struct packed {
    logic blk, p, u, b, w, l, pcr, ofr;
    logic [11:0] imm;
    logic [31:0] roff, base;
    logic [15:0] list;
    logic [31:0] eaddr;
    logic        wben;
    logic [31:0] wbval;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{0,1,1,0,0,1,0,0, 12'h010, 32'h0, 32'h100, 16'h0, 32'h110, 1'b0, 32'h110},   // R1
    '{0,1,0,0,1,1,0,0, 12'h008, 32'h0, 32'h100, 16'h0, 32'h0F8, 1'b1, 32'h0F8},   // R1 R3
    '{0,0,1,0,0,1,0,0, 12'h020, 32'h0, 32'h100, 16'h0, 32'h100, 1'b1, 32'h120},   // R2 R3
    '{0,1,1,1,0,1,0,0, 12'h003, 32'h0, 32'h100, 16'h0, 32'h103, 1'b0, 32'h103},   // R5
    '{0,1,0,0,1,1,0,1, 12'h000, 32'h40, 32'h100, 16'h0, 32'h0C0, 1'b1, 32'h0C0},  // R1 reg
    '{0,1,1,0,0,1,0,0, 12'hFFF, 32'h0, 32'h100, 16'h0, 32'h10FF, 1'b0, 32'h10FF}, // R1 max
    '{0,1,1,0,0,1,1,0, 12'h004, 32'h0, 32'h200, 16'h0, 32'h20C, 1'b0, 32'h20C},   // R9
    '{1,1,0,0,1,1,0,0, 12'h000, 32'h0, 32'h180, 16'h0005, 32'h178, 1'b1, 32'h178},// R7 DB
    '{1,0,0,0,0,1,0,0, 12'h000, 32'h0, 32'h180, 16'h8001, 32'h17C, 1'b0, 32'h178},// R7 DA
    '{1,0,1,0,1,1,0,0, 12'h000, 32'h0, 32'h140, 16'h00F0, 32'h140, 1'b1, 32'h150},// R7 IA
    '{1,1,1,0,1,1,1,0, 12'h000, 32'h0, 32'h138, 16'h0002, 32'h144, 1'b1, 32'h144},// R7 IB R9
    '{1,0,1,0,0,0,0,0, 12'h000, 32'h0, 32'h140, 16'h0003, 32'h140, 1'b0, 32'h148},// R11 block
    '{0,1,1,1,0,0,0,0, 12'h001, 32'h0, 32'h100, 16'h0, 32'h101, 1'b0, 32'h101},   // R11 byte
    '{0,0,0,0,0,0,0,0, 12'h010, 32'h0, 32'h108, 16'h0, 32'h108, 1'b1, 32'h0F8}    // R11 word
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    blk_mode = v.blk; pre_idx = v.p; add_off = v.u; byte_xfer = v.b; wb_req = v.w;
    load = v.l; pc_rel = v.pcr; off_is_reg = v.ofr; imm_off = v.imm; reg_off = v.roff;
    base_val = v.base; reg_list = v.list;
  endtask

  task automatic run_vec(input vec_t v, input int id);
    logic [31:0] ea [64];
    logic [3:0]  er [64];
    logic [1:0]  el [64];
    logic [31:0] exp_ld [16];
    logic [15:0] lst;
    logic [31:0] wa;
    int n = 0, seen = 0, bad = 0, cyc = 0;
    logic [31:0] bad_act = '0, bad_exp = '0;
    lst = v.blk ? v.list : 16'h0001;
    wa  = (v.b && !v.blk) ? v.eaddr : {v.eaddr[31:2], 2'b00};
    for (int r = 0; r < 16; r++) begin
      exp_ld[r] = '0;
      if (lst[r]) begin
        if (v.b && !v.blk) begin
          ea[n] = wa; er[n] = 4'(r); el[n] = 2'd0; n++;
          exp_ld[r] = {24'h0, mem[wa[7:0]]};
        end else begin
          for (int k = 0; k < 4; k++) begin
            logic [31:0] a;
            a = wa + 32'(k);
            ea[n] = a; er[n] = 4'(r); el[n] = 2'(k); n++;
            exp_ld[r][8*k +: 8] = mem[a[7:0]];
          end
          wa = wa + 32'd4;
        end
      end
    end
    @(negedge clk); drive(v); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(eff_addr == v.eaddr, $sformatf("R1/R2/R7/R9 eff_addr vec%0d", id), eff_addr, v.eaddr);
    chk(wb_en == v.wben, $sformatf("R3/R8 wb_en vec%0d", id), 32'(wb_en), 32'(v.wben));
    chk(wb_val == v.wbval, $sformatf("R3/R8 wb_val vec%0d", id), wb_val, v.wbval);
    forever begin
      if (bus_req) begin
        if (seen >= n || bus_addr != ea[seen] || bus_we != !v.l || xfer_reg != er[seen]
            || (!v.l && bus_wdata != {4'(el[seen]) + 4'd1, er[seen]})) begin
          if (bad == 0) begin
            bad_act = bus_addr; bad_exp = (seen < n) ? ea[seen] : 32'hFFFF_FFFF;
          end
          bad++;
        end
        seen++;
      end
      if (ld_valid)
        chk(lst[ld_reg] && ld_word == exp_ld[ld_reg],
            $sformatf("R4/R5/R6 ld_word vec%0d reg%0d", id, ld_reg), ld_word, exp_ld[ld_reg]);
      if (done) break;
      cyc++;
      if (cyc > 300) begin
        chk(1'b0, $sformatf("R10 no done vec%0d", id), 32'(cyc), 32'(n));
        break;
      end
      @(negedge clk);
    end
    chk(bad == 0 && seen == n, $sformatf("R4/R5/R6/R11 request sequence vec%0d", id),
        (bad != 0) ? bad_act : 32'(seen), (bad != 0) ? bad_exp : 32'(n));
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(!busy && !done && !bus_req && !ld_valid, "R10 reset outputs",
        {28'h0, busy, done, bus_req, ld_valid}, 32'h0);
    chk(!wb_en, "R10 reset wb_en", 32'(wb_en), 32'h0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R10: start while busy is ignored
    begin
      vec_t v;
      int nreq = 0;
      logic [31:0] first = 32'h0;
      v = TBL[0];
      v.imm = 12'h000; v.eaddr = 32'h100; v.wbval = 32'h100;
      @(negedge clk); drive(v); start = 1'b1;
      @(negedge clk); base_val = 32'h80; imm_off = 12'h020;
      for (int c = 0; c < 10; c++) begin
        if (bus_req) begin
          if (nreq == 0) first = bus_addr;
          nreq++;
        end
        if (c == 0) start = 1'b0;
        @(negedge clk);
      end
      chk(nreq == 4 && first == 32'h100, "R10 start ignored while busy (requests)", 32'(nreq), 32'd4);
      chk(eff_addr == 32'h100, "R10 start ignored while busy (eff_addr)", eff_addr, 32'h100);
      chk(!busy, "R10 idle after ignored start", 32'(busy), 32'h0);
    end

    // R10 / R8: empty register list
    begin
      vec_t v;
      v = TBL[9]; v.list = 16'h0000;
      @(negedge clk); drive(v); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy && !bus_req && !done, "R10 empty list first cycle",
          {29'h0, busy, bus_req, done}, 32'h4);
      chk(wb_en && wb_val == 32'h140, "R8 empty list writeback", wb_val, 32'h140);
      @(negedge clk);
      chk(done && !busy && !bus_req, "R10 empty list done",
          {29'h0, busy, bus_req, done}, 32'h1);
      @(negedge clk);
      chk(!done, "R10 done single pulse", 32'(done), 32'h0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule